// File: doc/BRIEF.md
# Paged Network Controller Command and Interrupt Register File

This block is the host-side control register file of a network controller. The host reaches it through a synchronous strobe bus with a 4-bit offset and 8-bit data. A 2-bit page field inside the command byte selects one of four register maps. Offset 0 is the command byte on every page. On the main page, some offsets return a status input when read but load a configuration register when written. The diagnostic page reads those configuration registers back.

The command byte carries five fields: stop, start, transmit request, the remote DMA command and the page select. Stopping is a handshake. The controller goes offline only once the engines report no activity in progress, and the offline state appears as the top bit of the interrupt status byte. Event pulses from the transmit, receive and DMA engines, together with rising edges of the tally counter MSBs, set sticky status flags. A mask selects which flags drive the single interrupt line.

Top module: `nic_ctl`

## Requirements
- R1: Command byte layout, from MSB to LSB: page[7:6], dma[5:3], txreq[2], start[1], stop[0]. Offset 0 reads and writes this byte on every page. Page 00 is main, 01 is station, 10 is diagnostic and 11 is reserved. The value after reset is 0x21.
- R2: On the main page, offset 4 reads the `tx_status` input and writes the transmit page start register. That register drives `tx_page_start` and reads back at diagnostic offset 4.
- R3: On the main page, offset 12 reads the `rx_status` input and writes the receive configuration register. That register drives `rx_cfg` and reads back at diagnostic offset 12.
- R4: On the station page, offsets 1 to 6 are read/write station address bytes. The byte at offset k drives `stn_addr[8k-1:8k-8]`.
- R5: While the stop bit is held, the offline flag sets on the first clock edge with `busy` low. It stays clear during every edge on which `busy` is high. The offline flag is driven on `offline` and reads as interrupt status bit 7. Both are 1 after reset.
- R6: A command write with start=1 and stop=0 clears the offline flag on that write's edge.
- R7: Writing 1 to txreq sets it and writing 0 leaves it unchanged. A `tx_done` pulse clears it. The bit drives `tx_req`.
- R8: Writing dma=000 leaves the dma field unchanged. Any other value is stored and driven on `dma_cmd`. Codes: 001 read, 010 write, 011 send packet, 1xx abort. The value after reset is 100.
- R9: Interrupt status bits 0 to 6 are: rx ok, tx ok, rx error, tx error, overwrite, counter overflow, DMA done. Each is sticky and sets on its event. A write to main offset 7 clears the bits written as 1. Writing 0 has no effect. Bit 7 is read-only. An event wins over a clear in the same cycle.
- R10: Status bit 5 sets on a 0-to-1 transition of any `tally_msb` bit. A level that stays high does not set it again.
- R11: The mask is written at main offset 15 and read at diagnostic offset 15. Mask bit 7 always reads 0. `irq` is the OR over bits 0 to 6 of status AND mask.
- R12: On the diagnostic and reserved pages, writes to offsets 1 to 15 have no effect. On the reserved page, reads of offsets 1 to 15 return 0x00. `rdata` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational |
| tx_status | input | 8 | Transmit status shown at main offset 4 |
| rx_status | input | 8 | Receive status shown at main offset 12 |
| busy | input | 1 | An engine activity is still in progress |
| tx_done | input | 1 | Transmission completed or aborted |
| ev_rx_ok | input | 1 | Packet received event |
| ev_tx_ok | input | 1 | Packet transmitted event |
| ev_rx_err | input | 1 | Receive error event |
| ev_tx_err | input | 1 | Transmit error event |
| ev_ovw | input | 1 | Receive ring overwrite event |
| ev_dma_done | input | 1 | Remote DMA complete event |
| tally_msb | input | 3 | MSBs of the three error tally counters |
| irq | output | 1 | Interrupt request |
| offline | output | 1 | Controller is in the stopped state |
| tx_req | output | 1 | Transmit request bit |
| dma_cmd | output | 3 | Remote DMA command field |
| tx_page_start | output | 8 | Transmit page start register |
| rx_cfg | output | 8 | Receive configuration register |
| stn_addr | output | 48 | Station address, offset 1 in the low byte |

## Verification
Two situations are hard to reach from the ports.

The first is the stop handshake held off by activity. To reach it, the bench raises `busy` before writing a stop command and holds it for several cycles. It checks that the offline flag stays clear through those cycles, then sets on the edge after `busy` falls.

The second is the edge-only behaviour of the counter-overflow flag. The bench clears the flag while a tally MSB is still high and confirms it stays clear. A second MSB is then raised, and the bench confirms that this new rising edge sets the flag again.

Beyond these directed cases, seeded random cycles mix event pulses, write-one-to-clear writes and mask writes in the same cycles. A bench model of the status and mask registers checks the results.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;
    localparam int unsigned DW      = 8;
    localparam int unsigned AW      = 4;
    localparam int unsigned N_EV    = 7;
    localparam int unsigned N_TALLY = 3;
    localparam int unsigned N_STN   = 6;
    localparam int unsigned DMA_W   = 3;
    localparam int unsigned CNT_BIT = 5;

    typedef enum logic [1:0] {
        PG_MAIN = 2'b00,
        PG_STN  = 2'b01,
        PG_DIAG = 2'b10,
        PG_RSVD = 2'b11
    } page_e;

    typedef struct packed {
        page_e              page;
        logic [DMA_W-1:0]   dma;
        logic               txp;
        logic               sta;
        logic               stp;
    } cmd_t;

    typedef struct packed {
        logic               cmd;
        logic               isr;
        logic               imr;
        logic               tps;
        logic               rxc;
        logic [N_STN-1:0]   stn;
    } wstrobe_t;

    localparam logic [AW-1:0] OFS_CMD = 4'd0;
    localparam logic [AW-1:0] OFS_TXS = 4'd4;
    localparam logic [AW-1:0] OFS_INT = 4'd7;
    localparam logic [AW-1:0] OFS_RXC = 4'd12;
    localparam logic [AW-1:0] OFS_MSK = 4'd15;

    localparam cmd_t CMD_RST = '{page: PG_MAIN, dma: 3'b100, txp: 1'b0, sta: 1'b0, stp: 1'b1};

    function automatic logic is_start(cmd_t c);
        return c.sta && !c.stp;
    endfunction

    function automatic logic [DMA_W-1:0] dma_next(logic [DMA_W-1:0] cur, logic [DMA_W-1:0] req);
        return (req == '0) ? cur : req;
    endfunction
endpackage

// File: rtl/nic_cmd_reg.sv
module nic_cmd_reg
    import nic_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    input  logic          tx_done,
    output cmd_t          cmd,
    output logic          offline
);
    cmd_t cmd_q;
    cmd_t wcmd;
    logic off_q;

    assign wcmd = cmd_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_RST;
            off_q <= 1'b1;
        end else begin
            if (we) begin
                cmd_q.page <= wcmd.page;
                cmd_q.dma  <= dma_next(cmd_q.dma, wcmd.dma);
                cmd_q.sta  <= wcmd.sta;
                cmd_q.stp  <= wcmd.stp;
            end
            // a new request written in the same cycle outranks completion
            if (we && wcmd.txp)
                cmd_q.txp <= 1'b1;
            else if (tx_done)
                cmd_q.txp <= 1'b0;
            // a start command outranks the pending stop handshake
            if (we && is_start(wcmd))
                off_q <= 1'b0;
            else if (cmd_q.stp && !busy)
                off_q <= 1'b1;
        end
    end

    assign cmd     = cmd_q;
    assign offline = off_q;
endmodule

// File: rtl/nic_tally_edge.sv
module nic_tally_edge
    import nic_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_TALLY-1:0] msb,
    output logic               rise
);
    logic [N_TALLY-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= msb;
    end

    assign rise = |(msb & ~prev_q);
endmodule

// File: rtl/nic_int_ctrl.sv
module nic_int_ctrl
    import nic_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_EV-1:0] ev,
    input  logic            isr_we,
    input  logic            imr_we,
    input  logic [N_EV-1:0] wbits,
    input  logic            offline,
    output logic [DW-1:0]   isr,
    output logic [DW-1:0]   imr,
    output logic            irq
);
    logic [N_EV-1:0] flag_q;
    logic [N_EV-1:0] msk_q;

    for (genvar i = 0; i < N_EV; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (ev[i])
                flag_q[i] <= 1'b1;
            else if (isr_we && wbits[i])
                flag_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         msk_q <= '0;
        else if (imr_we) msk_q <= wbits;
    end

    assign isr = {offline, flag_q};
    assign imr = {1'b0, msk_q};
    assign irq = |(flag_q & msk_q);
endmodule

// File: rtl/nic_page_decode.sv
module nic_page_decode
    import nic_ctl_pkg::*;
(
    input  page_e               page,
    input  logic [AW-1:0]       addr,
    input  logic                we,
    input  logic                re,
    input  logic [DW-1:0]       cr,
    input  logic [DW-1:0]       txs,
    input  logic [DW-1:0]       rxs,
    input  logic [DW-1:0]       isr,
    input  logic [DW-1:0]       imr,
    input  logic [DW-1:0]       tps,
    input  logic [DW-1:0]       rxc,
    input  logic [N_STN*DW-1:0] stn,
    output wstrobe_t            ws,
    output logic [DW-1:0]       rdata
);
    logic [DW-1:0] rd_mux;

    always_comb begin
        ws     = '0;
        ws.cmd = we && (addr == OFS_CMD);
        if (we && page == PG_MAIN) begin
            ws.isr = (addr == OFS_INT);
            ws.imr = (addr == OFS_MSK);
            ws.tps = (addr == OFS_TXS);
            ws.rxc = (addr == OFS_RXC);
        end
        if (we && page == PG_STN) begin
            for (int k = 0; k < N_STN; k++)
                ws.stn[k] = (addr == AW'(k + 1));
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == OFS_CMD) begin
            rd_mux = cr;
        end else begin
            case (page)
                PG_MAIN: begin
                    if (addr == OFS_TXS) rd_mux = txs;
                    if (addr == OFS_INT) rd_mux = isr;
                    if (addr == OFS_RXC) rd_mux = rxs;
                end
                PG_STN: begin
                    for (int k = 0; k < N_STN; k++)
                        if (addr == AW'(k + 1)) rd_mux = stn[k*DW +: DW];
                end
                PG_DIAG: begin
                    if (addr == OFS_TXS) rd_mux = tps;
                    if (addr == OFS_RXC) rd_mux = rxc;
                    if (addr == OFS_MSK) rd_mux = imr;
                end
                default: rd_mux = '0;
            endcase
        end
    end

    assign rdata = re ? rd_mux : '0;
endmodule

// File: rtl/nic_ctl.sv
module nic_ctl
    import nic_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [DW-1:0]      tx_status,
    input  logic [DW-1:0]      rx_status,
    input  logic               busy,
    input  logic               tx_done,
    input  logic               ev_rx_ok,
    input  logic               ev_tx_ok,
    input  logic               ev_rx_err,
    input  logic               ev_tx_err,
    input  logic               ev_ovw,
    input  logic               ev_dma_done,
    input  logic [N_TALLY-1:0] tally_msb,
    output logic               irq,
    output logic               offline,
    output logic               tx_req,
    output logic [DMA_W-1:0]   dma_cmd,
    output logic [DW-1:0]      tx_page_start,
    output logic [DW-1:0]      rx_cfg,
    output logic [N_STN*DW-1:0] stn_addr
);
    cmd_t            cmd_q;
    wstrobe_t        ws;
    logic            cnt_rise;
    logic [N_EV-1:0] ev_vec;
    logic [DW-1:0]   isr_v;
    logic [DW-1:0]   imr_v;
    logic [DW-1:0]   tps_q;
    logic [DW-1:0]   rxc_q;
    logic [N_STN*DW-1:0] stn_q;

    nic_cmd_reg u_cmd (
        .clk     (clk),
        .rst     (rst),
        .we      (ws.cmd),
        .wdata   (wdata),
        .busy    (busy),
        .tx_done (tx_done),
        .cmd     (cmd_q),
        .offline (offline)
    );

    nic_tally_edge u_tally (
        .clk  (clk),
        .rst  (rst),
        .msb  (tally_msb),
        .rise (cnt_rise)
    );

    assign ev_vec = {ev_dma_done, cnt_rise, ev_ovw, ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok};

    nic_int_ctrl u_int (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev_vec),
        .isr_we  (ws.isr),
        .imr_we  (ws.imr),
        .wbits   (wdata[N_EV-1:0]),
        .offline (offline),
        .isr     (isr_v),
        .imr     (imr_v),
        .irq     (irq)
    );

    nic_page_decode u_dec (
        .page  (cmd_q.page),
        .addr  (addr),
        .we    (wr_en),
        .re    (rd_en),
        .cr    (DW'(cmd_q)),
        .txs   (tx_status),
        .rxs   (rx_status),
        .isr   (isr_v),
        .imr   (imr_v),
        .tps   (tps_q),
        .rxc   (rxc_q),
        .stn   (stn_q),
        .ws    (ws),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tps_q <= '0;
            rxc_q <= '0;
        end else begin
            if (ws.tps) tps_q <= wdata;
            if (ws.rxc) rxc_q <= wdata;
        end
    end

    for (genvar k = 0; k < N_STN; k++) begin : g_stn
        always_ff @(posedge clk) begin
            if (rst)            stn_q[k*DW +: DW] <= '0;
            else if (ws.stn[k]) stn_q[k*DW +: DW] <= wdata;
        end
    end

    assign tx_req        = cmd_q.txp;
    assign dma_cmd       = cmd_q.dma;
    assign tx_page_start = tps_q;
    assign rx_cfg        = rxc_q;
    assign stn_addr      = stn_q;
endmodule

// File: rtl/nic_ctl_chk.sv
module nic_ctl_chk
    import nic_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [2:0]       wlow,
    input logic [DW-1:0]    rdata,
    input logic             busy,
    input logic             tx_done,
    input logic             tx_req,
    input logic             offline,
    input logic             irq,
    input page_e            page,
    input logic [DMA_W-1:0] dma,
    input logic [DW-1:0]    imr
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (addr == OFS_CMD);

    AST_START_CLEARS_OFFLINE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wlow[1] && !wlow[0]) |=> !offline); // R6

    AST_OFFLINE_WAITS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!offline && busy) |=> !offline); // R5

    AST_TXREQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !(cmd_wr && wlow[2])) |=> !tx_req); // R7

    AST_DMA_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (dma != 3'b000)); // R8

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && page == PG_RSVD && addr != OFS_CMD) |-> (rdata == '0)); // R12

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0)); // R12

    AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (imr == '0) |-> !irq); // R11
endmodule

bind nic_ctl nic_ctl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wlow    (wdata[2:0]),
    .rdata   (rdata),
    .busy    (busy),
    .tx_done (tx_done),
    .tx_req  (tx_req),
    .offline (offline),
    .irq     (irq),
    .page    (cmd_q.page),
    .dma     (cmd_q.dma),
    .imr     (imr_v)
);

// File: tb/nic_ctl_tb_top.sv
module nic_ctl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, rd_en = 0;
    logic [3:0]  addr = 0;
    logic [7:0]  wdata = 0, rdata;
    logic [7:0]  tx_status = 0, rx_status = 0;
    logic        busy = 0, tx_done = 0;
    logic        ev_rx_ok = 0, ev_tx_ok = 0, ev_rx_err = 0, ev_tx_err = 0, ev_ovw = 0, ev_dma_done = 0;
    logic [2:0]  tally_msb = 0;
    logic        irq, offline, tx_req;
    logic [2:0]  dma_cmd;
    logic [7:0]  tx_page_start, rx_cfg;
    logic [47:0] stn_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_ctl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tx_status(tx_status), .rx_status(rx_status), .busy(busy),
        .tx_done(tx_done), .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok), .ev_rx_err(ev_rx_err),
        .ev_tx_err(ev_tx_err), .ev_ovw(ev_ovw), .ev_dma_done(ev_dma_done),
        .tally_msb(tally_msb), .irq(irq), .offline(offline), .tx_req(tx_req),
        .dma_cmd(dma_cmd), .tx_page_start(tx_page_start), .rx_cfg(rx_cfg), .stn_addr(stn_addr)
    );

    function automatic logic exp_irq(logic [6:0] st, logic [6:0] mk);
        return |(st & mk);
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_ev(input logic [6:0] e);
        ev_rx_ok = e[0]; ev_tx_ok = e[1]; ev_rx_err = e[2]; ev_tx_err = e[3];
        ev_ovw = e[4]; ev_dma_done = e[6];
    endtask

    // one bus cycle with optional write and event pulses; returns at the next negedge
    task automatic cyc(input logic we, input logic [3:0] a, input logic [7:0] d, input logic [6:0] e);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; set_ev(e);
        @(negedge clk);
        wr_en = 0; set_ev(7'h00);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 7'h00);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1 d = rdata;
        rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [6:0]  m_isr;
        logic [6:0]  m_imr;
        logic [47:0] exp_stn;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        rst = 0;

        // reset state
        rd(4'd0, v);  check("R1 reset cmd", v, 8'h21);
        rd(4'd7, v);  check("R5 reset isr", v, 8'h80);
        check("R5 reset offline", offline, 1);
        check("R8 reset dma", dma_cmd, 3'b100);
        check("R11 reset irq", irq, 0);
        rd(4'd3, v);  check("R12 idle read", v, 8'h00);

        // start
        wr(4'd0, 8'h22);
        rd(4'd7, v);  check("R6 start clears", v, 8'h00);
        check("R6 offline low", offline, 0);

        // split read/write offsets on main page
        tx_status = 8'hC3; rx_status = 8'h21;
        wr(4'd4, 8'h5A);
        rd(4'd4, v);  check("R2 tx status read", v, 8'hC3);
        check("R2 tx page start out", tx_page_start, 8'h5A);
        wr(4'd12, 8'h1E);
        rd(4'd12, v); check("R3 rx status read", v, 8'h21);
        check("R3 rx cfg out", rx_cfg, 8'h1E);

        // station page
        wr(4'd0, 8'h62);
        rd(4'd0, v);  check("R1 page1 cmd", v, 8'h62);
        exp_stn = '0;
        for (int k = 1; k <= 6; k++) begin
            wr(4'(k), 8'(8'h10 + k * 3));
            exp_stn[(k-1)*8 +: 8] = 8'(8'h10 + k * 3);
        end
        for (int k = 1; k <= 6; k++) begin
            rd(4'(k), v); check("R4 station readback", v, 8'(8'h10 + k * 3));
        end
        check("R4 station out", stn_addr, exp_stn);

        // reserved page
        wr(4'd0, 8'hE2);
        rd(4'd0, v);  check("R1 page3 cmd", v, 8'hE2);
        wr(4'd4, 8'h99);
        wr(4'd15, 8'h7F);
        rd(4'd4, v);  check("R12 rsvd read 4", v, 8'h00);
        rd(4'd7, v);  check("R12 rsvd read 7", v, 8'h00);
        rd(4'd1, v);  check("R12 rsvd read 1", v, 8'h00);
        check("R12 rsvd write ignored", tx_page_start, 8'h5A);

        // diagnostic page
        wr(4'd0, 8'hA2);
        rd(4'd4, v);  check("R2 diag tps", v, 8'h5A);
        rd(4'd12, v); check("R3 diag rxc", v, 8'h1E);
        rd(4'd15, v); check("R12 imr untouched by rsvd", v, 8'h00);
        wr(4'd15, 8'h55);
        rd(4'd15, v); check("R12 diag write ignored", v, 8'h00);

        // transmit request
        wr(4'd0, 8'h26);
        check("R7 txreq set", tx_req, 1);
        wr(4'd0, 8'h22);
        rd(4'd0, v);  check("R7 write0 keeps", v, 8'h26);
        @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
        check("R7 done clears", tx_req, 0);
        rd(4'd0, v);  check("R7 cmd after done", v, 8'h22);

        // remote DMA field
        wr(4'd0, 8'h0A); check("R8 dma read", dma_cmd, 3'b001);
        wr(4'd0, 8'h02); check("R8 dma 000 keeps", dma_cmd, 3'b001);
        rd(4'd0, v);     check("R8 cmd readback", v, 8'h0A);
        wr(4'd0, 8'h1A); check("R8 dma send", dma_cmd, 3'b011);
        wr(4'd0, 8'h3A); check("R8 dma abort", dma_cmd, 3'b111);
        wr(4'd0, 8'h22);

        // counter overflow edge
        @(negedge clk); tally_msb = 3'b010; @(negedge clk);
        rd(4'd7, v);  check("R10 rise sets", v, 8'h20);
        wr(4'd7, 8'h20);
        rd(4'd7, v);  check("R10 level no reset", v, 8'h00);
        @(negedge clk); tally_msb = 3'b110; @(negedge clk);
        rd(4'd7, v);  check("R10 second rise", v, 8'h20);
        tally_msb = 3'b000;
        wr(4'd7, 8'h20);

        // status write-one-to-clear and read-only bit
        cyc(1'b0, 4'd0, 8'h00, 7'h01);
        rd(4'd7, v);  check("R9 rx ok set", v, 8'h01);
        wr(4'd7, 8'h00);
        rd(4'd7, v);  check("R9 write0 keeps", v, 8'h01);
        wr(4'd7, 8'h80);
        rd(4'd7, v);  check("R9 bit7 read-only", v, 8'h01);
        wr(4'd7, 8'h01);
        rd(4'd7, v);  check("R9 w1c clears", v, 8'h00);

        // mask register and reserved bit 7
        wr(4'd15, 8'hFF);
        wr(4'd0, 8'hA2);
        rd(4'd15, v); check("R11 mask bit7 zero", v, 8'h7F);
        wr(4'd0, 8'h22);
        wr(4'd15, 8'h00);

        // stop handshake held by activity
        busy = 1;
        wr(4'd0, 8'h21);
        repeat (3) @(negedge clk);
        check("R5 held while busy", offline, 0);
        rd(4'd7, v);  check("R5 isr while busy", v, 8'h00);
        busy = 0;
        @(negedge clk);
        check("R5 offline after idle", offline, 1);
        rd(4'd7, v);  check("R5 isr offline", v, 8'h80);
        wr(4'd0, 8'h22);
        check("R6 restart", offline, 0);

        // random events, clears and masks
        m_isr = '0; m_imr = '0;
        for (int i = 0; i < 300; i++) begin
            logic [6:0] e;
            logic [7:0] d;
            int sel;
            e   = 7'($urandom) & 7'h5F;
            if (($urandom % 3) != 0) e = '0;
            d   = 8'($urandom);
            sel = int'($urandom % 4);
            if (sel == 0) begin
                cyc(1'b1, 4'd7, d, e);
                m_isr = (m_isr & ~d[6:0]) | e;
            end else if (sel == 1) begin
                cyc(1'b1, 4'd15, d, e);
                m_isr = m_isr | e;
                m_imr = d[6:0];
            end else begin
                cyc(1'b0, 4'd0, 8'h00, e);
                m_isr = m_isr | e;
            end
            check("R11 irq", irq, exp_irq(m_isr, m_imr));
            rd(4'd7, v); check("R9 random isr", v, {1'b0, m_isr});
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule